// File: doc/BRIEF.md
# Lockable I/O Paging Register

This block is the paging control latch of an 8-bit CPU system with a 16-bit I/O address bus. The 64 KB CPU address space is split into four 16 KB slots. The block watches I/O write cycles and matches them with a partial, mask-based decode. On a match it stores a control byte. That byte picks the RAM bank placed in the top slot, the ROM image placed in the bottom slot, and the RAM bank that the video fetch logic reads the screen from.

The register is write-only. The block has no data output, so an I/O read at the decoded address leaves both the bus and the state alone.

A small state machine tracks a lock. It starts in `ST_OPEN`. An accepted write with the lock bit set moves it to `ST_LOCKED` (transition `LOCK_SET`). The write that sets the lock is itself stored. From then on every write to the port is dropped, and only reset returns the machine to `ST_OPEN` (transition `RESET_CLEAR`). In `ST_OPEN`, any other accepted write loops back to `ST_OPEN` (transition `OPEN_STORE`).

Top module: `page_ctl`

## Requirements
- R1: After reset, `top_bank`=0, `rom_sel`=0, `shadow_scr`=0, `scr_bank`=5 and `locked`=0.
- R2: A write is accepted on the rising clock edge where `io_req`=1, `io_wr`=1, `io_addr[15]`=0, `io_addr[14]`=1 and `io_addr[1]`=0. All other address bits are ignored. The new value shows on the outputs after that edge.
- R3: A write with `io_addr[15]`=1, `io_addr[14]`=0 or `io_addr[1]`=1 leaves every output unchanged.
- R4: An I/O cycle with `io_wr`=0 at a matching address changes nothing. The block drives no data.
- R5: Data bits 2:0 of an accepted write become `top_bank`. When `cpu_addr[15:14]`=3, `phys_addr` = {`top_bank`, `cpu_addr[13:0]`} and `rom_hit`=0.
- R6: When `cpu_addr[15:14]`=1, `phys_addr` = {3'd5, `cpu_addr[13:0]`}. When `cpu_addr[15:14]`=2, `phys_addr` = {3'd2, `cpu_addr[13:0]`}. Neither depends on the register.
- R7: Data bit 4 becomes `rom_sel`. When `cpu_addr[15:14]`=0, `rom_hit`=1 and `phys_addr` = {2'b00, `rom_sel`, `cpu_addr[13:0]`}.
- R8: Data bit 3 becomes `shadow_scr`. `scr_bank` is 7 when `shadow_scr`=1 and 5 otherwise, and depends on nothing else.
- R9: An accepted write with data bit 5 set stores its other fields and sets `locked` from the next cycle. While `locked`=1, every write is ignored, and only reset clears the lock.
- R10: Data bits 7:6 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | I/O cycle in progress |
| io_wr | input | 1 | I/O cycle is a write |
| io_addr | input | 16 | I/O address |
| io_data | input | 8 | I/O write data |
| cpu_addr | input | 16 | CPU memory address to translate |
| phys_addr | output | 17 | Physical address: RAM bank and offset, or ROM image and offset |
| rom_hit | output | 1 | Current `cpu_addr` lies in the ROM slot |
| top_bank | output | 3 | RAM bank mapped into the top slot |
| rom_sel | output | 1 | ROM image select |
| shadow_scr | output | 1 | Shadow screen selected |
| scr_bank | output | 3 | RAM bank the video fetch reads |
| locked | output | 1 | Paging lock is set |

## Verification
Some behaviour the assertions check on every cycle:
- the lock never clears and, once set, the stored fields never move;
- no cycle without a write strobe changes the stored fields, and neither does a write whose address fails the mask;
- an accepted open write lands in the bank field;
- the slot translation and the screen bank always agree with the stored fields.

The bench scenarios show what the properties cannot: the decode accepts the loosest matching address as well as the usual one, bits 7:6 are really discarded, the locking write keeps its own fields, and a second reset clears the lock.

// File: rtl/page_ctl_pkg.sv
package page_ctl_pkg;

    localparam int BANK_W   = 3;
    localparam int OFFS_W   = 14;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 16;

    // field positions inside the control byte
    localparam int FLD_BANK = 0;
    localparam int FLD_SCR  = 3;
    localparam int FLD_ROM  = 4;
    localparam int FLD_LOCK = 5;

    typedef enum logic [0:0] {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              rom;
        logic              shadow;
    } page_cfg_t;

endpackage

// File: rtl/page_decode.sv
module page_decode #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MATCH_MASK = 16'hC002,
    parameter logic [ADDR_W-1:0] MATCH_VAL  = 16'h4000
) (
    input  logic              io_req,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              wr_hit
);

    logic addr_match;

    always_comb begin
        addr_match = ((io_addr & MATCH_MASK) == MATCH_VAL);
        wr_hit     = io_req && io_wr && addr_match;
    end

endmodule

// File: rtl/page_lock_fsm.sv
module page_lock_fsm
    import page_ctl_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    output page_cfg_t     cfg,
    output logic          locked
);

    lock_state_e state_q, state_d;
    page_cfg_t   cfg_d;
    page_cfg_t   cfg_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_d;
        end
    end

    // next state and stored fields
    always_comb begin
        state_d = state_q;
        cfg_d   = cfg_q;
        unique case (state_q)
            ST_OPEN: begin
                if (wr_hit) begin
                    cfg_d.bank   = wr_data[FLD_BANK +: BANK_W];
                    cfg_d.rom    = wr_data[FLD_ROM];
                    cfg_d.shadow = wr_data[FLD_SCR];
                    if (wr_data[FLD_LOCK])
                        state_d = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                state_d = ST_LOCKED;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        cfg    = cfg_q;
        locked = (state_q == ST_LOCKED);
    end

endmodule

// File: rtl/page_map.sv
module page_map
    import page_ctl_pkg::*;
#(
    parameter int              AW          = ADDR_W,
    parameter int              OW          = OFFS_W,
    parameter int              BW          = BANK_W,
    parameter logic [BW-1:0]   SLOT1_BANK  = 3'd5,
    parameter logic [BW-1:0]   SLOT2_BANK  = 3'd2,
    parameter logic [BW-1:0]   NORMAL_SCR  = 3'd5,
    parameter logic [BW-1:0]   SHADOW_SCR  = 3'd7
) (
    input  logic [AW-1:0]    cpu_addr,
    input  page_cfg_t        cfg,
    output logic [BW+OW-1:0] phys_addr,
    output logic             rom_hit,
    output logic [BW-1:0]    scr_bank
);

    localparam int SLOT_W = AW - OW;

    logic [SLOT_W-1:0] slot;
    logic [OW-1:0]     offs;
    logic [BW-1:0]     sel_bank;

    always_comb begin
        slot     = cpu_addr[AW-1:OW];
        offs     = cpu_addr[OW-1:0];
        rom_hit  = 1'b0;
        sel_bank = '0;
        unique case (slot)
            2'd0: begin
                rom_hit  = 1'b1;
                sel_bank = {{(BW-1){1'b0}}, cfg.rom};
            end
            2'd1: sel_bank = SLOT1_BANK;
            2'd2: sel_bank = SLOT2_BANK;
            2'd3: sel_bank = cfg.bank;
            default: sel_bank = '0;
        endcase
        phys_addr = {sel_bank, offs};
        scr_bank  = cfg.shadow ? SHADOW_SCR : NORMAL_SCR;
    end

endmodule

// File: rtl/page_ctl.sv
module page_ctl
    import page_ctl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MATCH_MASK = 16'hC002,
    parameter logic [ADDR_W-1:0] MATCH_VAL  = 16'h4000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     io_req,
    input  logic                     io_wr,
    input  logic [ADDR_W-1:0]        io_addr,
    input  logic [DATA_W-1:0]        io_data,
    input  logic [ADDR_W-1:0]        cpu_addr,
    output logic [BANK_W+OFFS_W-1:0] phys_addr,
    output logic                     rom_hit,
    output logic [BANK_W-1:0]        top_bank,
    output logic                     rom_sel,
    output logic                     shadow_scr,
    output logic [BANK_W-1:0]        scr_bank,
    output logic                     locked
);

    logic      wr_hit;
    page_cfg_t cfg;

    page_decode #(
        .ADDR_W     (ADDR_W),
        .MATCH_MASK (MATCH_MASK),
        .MATCH_VAL  (MATCH_VAL)
    ) u_decode (
        .io_req  (io_req),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .wr_hit  (wr_hit)
    );

    page_lock_fsm #(.DW(DATA_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_data (io_data),
        .cfg     (cfg),
        .locked  (locked)
    );

    page_map u_map (
        .cpu_addr  (cpu_addr),
        .cfg       (cfg),
        .phys_addr (phys_addr),
        .rom_hit   (rom_hit),
        .scr_bank  (scr_bank)
    );

    assign top_bank   = cfg.bank;
    assign rom_sel    = cfg.rom;
    assign shadow_scr = cfg.shadow;

endmodule

// File: rtl/page_ctl_chk.sv
module page_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_req,
    input logic        io_wr,
    input logic [15:0] io_addr,
    input logic [7:0]  io_data,
    input logic [15:0] cpu_addr,
    input logic [16:0] phys_addr,
    input logic        rom_hit,
    input logic [2:0]  top_bank,
    input logic        rom_sel,
    input logic        shadow_scr,
    input logic [2:0]  scr_bank,
    input logic        locked
);

    logic bad_addr;
    assign bad_addr = io_addr[15] || !io_addr[14] || io_addr[1];

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R9

    AST_FROZEN_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable({top_bank, rom_sel, shadow_scr})); // R9

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_req && io_wr) |=> $stable({top_bank, rom_sel, shadow_scr, locked})); // R4

    AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && io_wr && bad_addr) |=> $stable({top_bank, rom_sel, shadow_scr, locked})); // R3

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && io_wr && !bad_addr && !locked) |=> (top_bank == $past(io_data[2:0]))); // R2

    AST_TOP_SLOT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'd3) |-> (phys_addr == {top_bank, cpu_addr[13:0]} && !rom_hit)); // R5

    AST_MID_SLOT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'd1) |-> (phys_addr[16:14] == 3'd5)); // R6

    AST_ROM_SLOT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'd0) |-> (rom_hit && phys_addr[14] == rom_sel)); // R7

    AST_SCREEN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        scr_bank == (shadow_scr ? 3'd7 : 3'd5)); // R8

endmodule

bind page_ctl page_ctl_chk u_chk (.*);

// File: tb/page_ctl_tb.sv
module page_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_data = '0;
    logic [15:0] cpu_addr = '0;
    logic [16:0] phys_addr;
    logic        rom_hit;
    logic [2:0]  top_bank;
    logic        rom_sel;
    logic        shadow_scr;
    logic [2:0]  scr_bank;
    logic        locked;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    page_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
        .io_addr(io_addr), .io_data(io_data), .cpu_addr(cpu_addr),
        .phys_addr(phys_addr), .rom_hit(rom_hit), .top_bank(top_bank),
        .rom_sel(rom_sel), .shadow_scr(shadow_scr), .scr_bank(scr_bank),
        .locked(locked)
    );

    typedef struct {
        logic [2:0] bank;
        logic       rom;
        logic       shd;
        logic       lck;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    // reference model
    logic [2:0] m_bank = '0;
    logic       m_rom = 1'b0;
    logic       m_shd = 1'b0;
    logic       m_lck = 1'b0;

    function automatic void push_exp(string tag);
        exp_t e;
        e.bank = m_bank; e.rom = m_rom; e.shd = m_shd; e.lck = m_lck; e.tag = tag;
        sb_q.push_back(e);
    endfunction

    task automatic do_reset(string tag);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_bank = '0; m_rom = 1'b0; m_shd = 1'b0; m_lck = 1'b0;
        push_exp(tag);
    endtask

    task automatic io_cycle(input logic wr, input logic [15:0] a,
                            input logic [7:0] d, string tag);
        @(negedge clk);
        io_req = 1'b1; io_wr = wr; io_addr = a; io_data = d;
        @(negedge clk);
        io_req = 1'b0; io_wr = 1'b0;
        if (wr && !a[15] && a[14] && !a[1] && !m_lck) begin
            m_bank = d[2:0];
            m_rom  = d[4];
            m_shd  = d[3];
            m_lck  = d[5];
        end
        push_exp(tag);
    endtask

    task automatic check_map(input logic [15:0] ca, string tag);
        logic [16:0] ep;
        logic        er;
        @(negedge clk);
        cpu_addr = ca;
        #1;
        unique case (ca[15:14])
            2'd0: begin ep = {2'b00, m_rom, ca[13:0]}; er = 1'b1; end
            2'd1: begin ep = {3'd5, ca[13:0]}; er = 1'b0; end
            2'd2: begin ep = {3'd2, ca[13:0]}; er = 1'b0; end
            default: begin ep = {m_bank, ca[13:0]}; er = 1'b0; end
        endcase
        total++;
        if (phys_addr !== ep || rom_hit !== er) begin
            bad++;
            $display("FAIL %s: phys=%h rom_hit=%b expected phys=%h rom_hit=%b",
                     tag, phys_addr, rom_hit, ep, er);
        end
    endtask

    // monitor: compare scoreboard items after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t e;
                logic [2:0] es;
                e = sb_q.pop_front();
                es = e.shd ? 3'd7 : 3'd5;
                total++;
                if (top_bank !== e.bank || rom_sel !== e.rom || shadow_scr !== e.shd ||
                    locked !== e.lck || scr_bank !== es) begin
                    bad++;
                    $display("FAIL %s: bank=%0d rom=%b shd=%b lck=%b scr=%0d expected bank=%0d rom=%b shd=%b lck=%b scr=%0d",
                             e.tag, top_bank, rom_sel, shadow_scr, locked, scr_bank,
                             e.bank, e.rom, e.shd, e.lck, es);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset state");
        io_cycle(1'b1, 16'h7FFD, 8'h13, "R2 R5 R7 usual address write");
        check_map(16'hC123, "R5 top slot translation");
        check_map(16'h0456, "R7 rom slot with rom 1");
        io_cycle(1'b1, 16'h4000, 8'h0E, "R2 R8 loosest matching address, shadow on");
        check_map(16'hFFFF, "R5 top slot bank 6");
        io_cycle(1'b1, 16'hFFFD, 8'h07, "R3 bit15 set ignored");
        io_cycle(1'b1, 16'h3FFD, 8'h07, "R3 bit14 clear ignored");
        io_cycle(1'b1, 16'h7FFF, 8'h07, "R3 bit1 set ignored");
        io_cycle(1'b0, 16'h7FFD, 8'h31, "R4 read cycle ignored");
        io_cycle(1'b1, 16'h7FFD, 8'hC5, "R10 bits 7:6 ignored");
        check_map(16'h5A5A, "R6 slot 1 fixed bank 5");
        check_map(16'h8001, "R6 slot 2 fixed bank 2");
        check_map(16'h1234, "R7 rom slot with rom 0");
        io_cycle(1'b1, 16'h7FFD, 8'h39, "R9 locking write stored");
        io_cycle(1'b1, 16'h7FFD, 8'h06, "R9 write after lock ignored");
        io_cycle(1'b1, 16'h4000, 8'h10, "R9 second write after lock ignored");
        check_map(16'hC000, "R9 top slot still bank 1");
        do_reset("R1 reset clears lock");
        io_cycle(1'b1, 16'h7FFD, 8'h02, "R9 write accepted after reset");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule